// File: doc/BRIEF.md
# Deferred-Binding Register Rename Unit

This unit renames architectural destination registers with storage-free tags at decode and binds a real physical register to a tag only when the producing instruction finishes execution. Dependence tracking uses a logical-to-tag alias table. Storage is tracked in a second table that maps each tag to a physical register index and holds a bound flag. Tags outnumber physical registers, so decode can run ahead of storage. A physical register is held only from the moment its value exists until the next writer of the same logical register commits.

Three ports drive the unit:
- The decode port takes two logical sources and one logical destination. It returns the source tags, their readiness and their physical indices, and the new destination tag.
- The writeback port takes a tag and either grants a physical register in the same cycle or refuses it.
- The commit port retires the oldest in-flight instruction. It frees the tag that the instruction superseded, together with that tag's physical register when one is bound.

An in-order record of superseded tags sits between decode and commit and bounds the number of in-flight instructions.

Top module: `vp_rename`

## Requirements
- R1: After reset, logical register r maps to tag r for r in 0..31. Tags 0..31 are bound to physical registers 0..31, so sources report ready with physical index equal to r. Tags 32..63 and physical registers 32..47 are free. The record is empty, `dec_ready` is 1 and the offered destination tag is 32.
- R2: A decode fires when `dec_valid` and `dec_ready` are both 1. It takes the lowest-numbered free tag, which is shown on `dec_dst_tag`. That tag leaves the free list from the next cycle.
- R3: Source tags come from the alias table as it stood before the current cycle's decode. A source naming the same logical register as the same-cycle destination therefore sees the older tag, and later decodes see the new tag.
- R4: A source reports ready, with the bound physical index, only if its tag was bound at the start of the cycle. Otherwise ready is 0 and the physical index is 0.
- R5: A writeback request for an allocated tag that is unbound is granted in the same cycle when any physical register is free. The grant returns the lowest-numbered free physical register, and the binding is visible to sources from the next cycle.
- R6: A writeback request is refused, with `wb_grant` 0 and `wb_phys` 0, when no physical register is free or when the tag is already bound. The tag's state is unchanged and decode is unaffected. Requests naming a free tag are not supported.
- R7: When the record is not empty, a commit request pops the oldest entry. The superseded tag appears on `cm_rel_tag`, and `cm_rel_phys_vld` and `cm_rel_phys` show whether it was bound and to which register. The tag, and its physical register when bound, become free from the next cycle and the tag becomes unbound.
- R8: A commit request while the record is empty is ignored: `cm_accept` stays 0 and no state changes.
- R9: `dec_ready` is 0 when no tag is free or the 32-entry record is full. A commit in the same cycle does not lift the stall. A decode request while `dec_ready` is 0 changes nothing.
- R10: No tag and no physical register is ever lost or held twice. Free tags plus record entries always equal 32, and free physical registers plus bound tags always equal 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode request |
| dec_src_a | input | 5 | Logical source A |
| dec_src_b | input | 5 | Logical source B |
| dec_dst | input | 5 | Logical destination |
| dec_ready | output | 1 | Decode can be accepted this cycle |
| dec_dst_tag | output | 6 | Tag given to the destination |
| dec_a_tag | output | 6 | Tag of source A |
| dec_a_rdy | output | 1 | Source A tag is bound |
| dec_a_phys | output | 6 | Physical register of source A (0 if not ready) |
| dec_b_tag | output | 6 | Tag of source B |
| dec_b_rdy | output | 1 | Source B tag is bound |
| dec_b_phys | output | 6 | Physical register of source B (0 if not ready) |
| wb_valid | input | 1 | Writeback binding request |
| wb_tag | input | 6 | Tag asking for storage |
| wb_grant | output | 1 | Physical register granted |
| wb_phys | output | 6 | Granted physical register (0 when refused) |
| cm_valid | input | 1 | Commit request for the oldest instruction |
| cm_accept | output | 1 | Commit taken |
| cm_rel_tag | output | 6 | Superseded tag released |
| cm_rel_phys_vld | output | 1 | Released tag had a physical register |
| cm_rel_phys | output | 6 | Physical register released (0 if none) |

## Verification
The first traffic pattern is a decode-heavy burst with few commits. It fills the record and drains the tag list, which separates a correct stall from one that is lost or comes too early. The second is a writeback-heavy phase with no commits, which runs the physical pool dry and shows whether refusals keep tags unbound while decode keeps flowing. In a long mixed phase, same-register sources and destinations and writebacks to already-bound tags test the before-update translation and the refusal rule against a behavioural model of both tables. A final drain commits everything and then decodes until the stall, and exactly 32 decodes must fire, which exposes any leaked tag.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    localparam int unsigned LOG_N  = 32;
    localparam int unsigned TAG_N  = 64;
    localparam int unsigned PHYS_N = 48;
    localparam int unsigned HIST_N = 32;

    localparam int unsigned LOG_W  = $clog2(LOG_N);
    localparam int unsigned TAG_W  = $clog2(TAG_N);
    localparam int unsigned PHYS_W = $clog2(PHYS_N);
    localparam int unsigned HCNT_W = $clog2(HIST_N + 1);

    typedef logic [LOG_W-1:0]  lreg_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [PHYS_W-1:0] preg_t;
    typedef logic [HCNT_W-1:0] hcnt_t;

    typedef struct packed {
        logic  bound;
        preg_t preg;
    } bind_ent_t;

    typedef struct packed {
        logic      accept;
        tag_t      tag;
        bind_ent_t ent;
    } release_t;

    typedef struct packed {
        tag_t  tag;
        logic  rdy;
        preg_t preg;
    } src_view_t;

    function automatic src_view_t make_view(tag_t t, bind_ent_t e);
        src_view_t v;
        v.tag  = t;
        v.rdy  = e.bound;
        v.preg = e.bound ? e.preg : '0;
        return v;
    endfunction
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
    parameter int unsigned N          = 64,
    parameter int unsigned RESET_USED = 32,
    parameter int unsigned IDX_W      = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             any_free,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [N-1:0]     free_vec
);
    logic [N-1:0] vec_q;

    always_comb begin
        any_free  = 1'b0;
        alloc_idx = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (vec_q[i]) begin
                any_free  = 1'b1;
                alloc_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(N); i++) begin
                vec_q[i] <= (i >= int'(RESET_USED));
            end
        end else begin
            if (alloc_en && any_free) begin
                vec_q[alloc_idx] <= 1'b0;
            end
            if (rel_en) begin
                vec_q[rel_idx] <= 1'b1;
            end
        end
    end

    assign free_vec = vec_q;
endmodule

// File: rtl/rn_alias_map.sv
`timescale 1ns/1ps
module rn_alias_map #(
    parameter int unsigned LOG_N = 32,
    parameter int unsigned TAG_W = 6,
    parameter int unsigned NRD   = 3,
    parameter int unsigned LOG_W = $clog2(LOG_N)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NRD-1:0][LOG_W-1:0] rd_lreg,
    output logic [NRD-1:0][TAG_W-1:0] rd_tag,
    input  logic                      wr_en,
    input  logic [LOG_W-1:0]          wr_lreg,
    input  logic [TAG_W-1:0]          wr_tag
);
    logic [TAG_W-1:0] tbl_q [LOG_N];

    for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
        assign rd_tag[g] = tbl_q[rd_lreg[g]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(LOG_N); i++) begin
                tbl_q[i] <= TAG_W'(i);
            end
        end else if (wr_en) begin
            tbl_q[wr_lreg] <= wr_tag;
        end
    end
endmodule

// File: rtl/rn_bind_table.sv
`timescale 1ns/1ps
module rn_bind_table
    import rn_pkg::*;
#(
    parameter int unsigned NRD         = 3,
    parameter int unsigned RESET_BOUND = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tag_t [NRD-1:0]        rd_tag,
    output bind_ent_t [NRD-1:0]   rd_ent,
    input  logic                  set_en,
    input  tag_t                  set_tag,
    input  preg_t                 set_preg,
    input  logic                  clr_en,
    input  tag_t                  clr_tag,
    output logic [TAG_N-1:0]      bound_vec
);
    bind_ent_t ent_q [TAG_N];

    for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
        assign rd_ent[g] = ent_q[rd_tag[g]];
    end

    for (genvar t = 0; t < int'(TAG_N); t++) begin : g_vec
        assign bound_vec[t] = ent_q[t].bound;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(TAG_N); i++) begin
                ent_q[i].bound <= (i < int'(RESET_BOUND));
                ent_q[i].preg  <= (i < int'(RESET_BOUND)) ? PHYS_W'(i) : '0;
            end
        end else begin
            if (clr_en) begin
                ent_q[clr_tag].bound <= 1'b0;
            end
            if (set_en) begin
                ent_q[set_tag].bound <= 1'b1;
                ent_q[set_tag].preg  <= set_preg;
            end
        end
    end
endmodule

// File: rtl/rn_history.sv
`timescale 1ns/1ps
module rn_history #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned W     = 6,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= bump(wr_q);
            end
            if (pop) begin
                rd_q <= bump(rd_q);
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_data = mem_q[rd_q];
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign count     = cnt_q;
endmodule

// File: rtl/vp_rename.sv
`timescale 1ns/1ps
module vp_rename
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  dec_valid,
    input  lreg_t dec_src_a,
    input  lreg_t dec_src_b,
    input  lreg_t dec_dst,
    output logic  dec_ready,
    output tag_t  dec_dst_tag,
    output tag_t  dec_a_tag,
    output logic  dec_a_rdy,
    output preg_t dec_a_phys,
    output tag_t  dec_b_tag,
    output logic  dec_b_rdy,
    output preg_t dec_b_phys,
    input  logic  wb_valid,
    input  tag_t  wb_tag,
    output logic  wb_grant,
    output preg_t wb_phys,
    input  logic  cm_valid,
    output logic  cm_accept,
    output tag_t  cm_rel_tag,
    output logic  cm_rel_phys_vld,
    output preg_t cm_rel_phys
);
    localparam int unsigned RD_A   = 0;
    localparam int unsigned RD_B   = 1;
    localparam int unsigned RD_DST = 2;
    localparam int unsigned RD_OLD = 2;

    logic                    dec_fire;
    logic                    tag_any, phys_any;
    tag_t                    tag_new;
    preg_t                   phys_new;
    logic [TAG_N-1:0]        tag_free_vec;
    logic [PHYS_N-1:0]       phys_free_vec;
    logic [TAG_N-1:0]        bound_vec;
    lreg_t [2:0]             map_rd_lreg;
    tag_t  [2:0]             map_rd_tag;
    tag_t  [2:0]             bt_rd_tag;
    bind_ent_t [2:0]         bt_rd_ent;
    logic                    hist_full, hist_empty;
    tag_t                    hist_head;
    hcnt_t                   hist_cnt;
    src_view_t               view_a, view_b;
    release_t                rel;

    // decode side
    assign dec_ready = tag_any && !hist_full;
    assign dec_fire  = dec_valid && dec_ready;

    assign map_rd_lreg[RD_A]   = dec_src_a;
    assign map_rd_lreg[RD_B]   = dec_src_b;
    assign map_rd_lreg[RD_DST] = dec_dst;

    rn_alias_map #(.LOG_N(LOG_N), .TAG_W(TAG_W), .NRD(3)) u_alias (
        .clk     (clk),
        .rst     (rst),
        .rd_lreg (map_rd_lreg),
        .rd_tag  (map_rd_tag),
        .wr_en   (dec_fire),
        .wr_lreg (dec_dst),
        .wr_tag  (tag_new)
    );

    rn_free_list #(.N(TAG_N), .RESET_USED(LOG_N)) u_tag_free (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (dec_fire),
        .rel_en    (rel.accept),
        .rel_idx   (rel.tag),
        .any_free  (tag_any),
        .alloc_idx (tag_new),
        .free_vec  (tag_free_vec)
    );

    rn_history #(.DEPTH(HIST_N), .W(TAG_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .push      (dec_fire),
        .push_data (map_rd_tag[RD_DST]),
        .pop       (rel.accept),
        .head_data (hist_head),
        .full      (hist_full),
        .empty     (hist_empty),
        .count     (hist_cnt)
    );

    // storage binding side
    assign bt_rd_tag[RD_A]   = map_rd_tag[RD_A];
    assign bt_rd_tag[RD_B]   = map_rd_tag[RD_B];
    assign bt_rd_tag[RD_OLD] = hist_head;

    rn_bind_table #(.NRD(3), .RESET_BOUND(LOG_N)) u_bind (
        .clk       (clk),
        .rst       (rst),
        .rd_tag    (bt_rd_tag),
        .rd_ent    (bt_rd_ent),
        .set_en    (wb_grant),
        .set_tag   (wb_tag),
        .set_preg  (phys_new),
        .clr_en    (rel.accept),
        .clr_tag   (rel.tag),
        .bound_vec (bound_vec)
    );

    rn_free_list #(.N(PHYS_N), .RESET_USED(LOG_N)) u_phys_free (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (wb_grant),
        .rel_en    (rel.accept && rel.ent.bound),
        .rel_idx   (rel.ent.preg),
        .any_free  (phys_any),
        .alloc_idx (phys_new),
        .free_vec  (phys_free_vec)
    );

    assign wb_grant = wb_valid && !bound_vec[wb_tag] && phys_any;
    assign wb_phys  = wb_grant ? phys_new : '0;

    // commit side
    always_comb begin
        rel.accept = cm_valid && !hist_empty;
        rel.tag    = hist_head;
        rel.ent    = bt_rd_ent[RD_OLD];
    end

    assign cm_accept       = rel.accept;
    assign cm_rel_tag      = rel.tag;
    assign cm_rel_phys_vld = rel.ent.bound;
    assign cm_rel_phys     = rel.ent.bound ? rel.ent.preg : '0;

    // source views
    assign view_a = make_view(map_rd_tag[RD_A], bt_rd_ent[RD_A]);
    assign view_b = make_view(map_rd_tag[RD_B], bt_rd_ent[RD_B]);

    assign dec_dst_tag = tag_new;
    assign dec_a_tag   = view_a.tag;
    assign dec_a_rdy   = view_a.rdy;
    assign dec_a_phys  = view_a.preg;
    assign dec_b_tag   = view_b.tag;
    assign dec_b_rdy   = view_b.rdy;
    assign dec_b_phys  = view_b.preg;
endmodule

// File: rtl/vp_rename_chk.sv
`timescale 1ns/1ps
module vp_rename_chk
    import rn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic              dec_ready,
    input tag_t              dec_dst_tag,
    input logic              wb_valid,
    input tag_t              wb_tag,
    input logic              wb_grant,
    input logic              cm_accept,
    input logic [TAG_N-1:0]  tag_free_vec,
    input logic [PHYS_N-1:0] phys_free_vec,
    input logic [TAG_N-1:0]  bound_vec,
    input hcnt_t             hist_cnt
);
    p_dst_was_free_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready) |-> tag_free_vec[dec_dst_tag]);

    p_dst_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready) |=> !tag_free_vec[$past(dec_dst_tag)]);

    p_bind_visible_r5: assert property (@(posedge clk) disable iff (rst)
        wb_grant |=> bound_vec[$past(wb_tag)]);

    p_refuse_dry_r6: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && (phys_free_vec == '0)) |-> !wb_grant);

    p_empty_commit_r8: assert property (@(posedge clk) disable iff (rst)
        (hist_cnt == '0) |-> !cm_accept);

    p_stall_full_r9: assert property (@(posedge clk) disable iff (rst)
        (hist_cnt == hcnt_t'(HIST_N)) |-> !dec_ready);

    p_tag_balance_r10: assert property (@(posedge clk) disable iff (rst)
        ($countones(tag_free_vec) + int'(hist_cnt)) == int'(TAG_N - LOG_N));

    p_phys_balance_r10: assert property (@(posedge clk) disable iff (rst)
        ($countones(phys_free_vec) + $countones(bound_vec)) == int'(PHYS_N));
endmodule

bind vp_rename vp_rename_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_valid     (dec_valid),
    .dec_ready     (dec_ready),
    .dec_dst_tag   (dec_dst_tag),
    .wb_valid      (wb_valid),
    .wb_tag        (wb_tag),
    .wb_grant      (wb_grant),
    .cm_accept     (cm_accept),
    .tag_free_vec  (tag_free_vec),
    .phys_free_vec (phys_free_vec),
    .bound_vec     (bound_vec),
    .hist_cnt      (hist_cnt)
);

// File: tb/vp_rename_bench.sv
`timescale 1ns/1ps
module vp_rename_bench;
    import rn_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  dec_valid = 1'b0;
    lreg_t dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic  dec_ready, dec_a_rdy, dec_b_rdy;
    tag_t  dec_dst_tag, dec_a_tag, dec_b_tag;
    preg_t dec_a_phys, dec_b_phys;
    logic  wb_valid = 1'b0;
    tag_t  wb_tag = '0;
    logic  wb_grant;
    preg_t wb_phys;
    logic  cm_valid = 1'b0;
    logic  cm_accept, cm_rel_phys_vld;
    tag_t  cm_rel_tag;
    preg_t cm_rel_phys;

    always #4 clk = ~clk;

    vp_rename u_vp_rename (.*);

    // behavioural reference state
    typedef struct { int old_t; int new_t; } rec_t;
    int   m_map   [32];
    bit   m_bound [64];
    int   m_pmap  [64];
    bit   m_tfree [64];
    bit   m_pfree [48];
    rec_t m_q [$];

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;
    bit last_fire;

    function automatic int low_tag();
        for (int i = 0; i < 64; i++) if (m_tfree[i]) return i;
        return -1;
    endfunction

    function automatic int low_phys();
        for (int i = 0; i < 48; i++) if (m_pfree[i]) return i;
        return -1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit dv, int sa, int sb, int sd, bit wv, int wt, bit cv);
        int  nt, np, ta, tb, old;
        bit  er, eg, ea;
        @(negedge clk);
        dec_valid = dv; dec_src_a = lreg_t'(sa); dec_src_b = lreg_t'(sb); dec_dst = lreg_t'(sd);
        wb_valid = wv; wb_tag = tag_t'(wt); cm_valid = cv;
        #1;
        nt = low_tag();
        np = low_phys();
        er = (nt >= 0) && (m_q.size() < 32);
        chk("R9", "dec_ready", int'(dec_ready), int'(er));
        if (er) chk("R2", "dst_tag", int'(dec_dst_tag), nt);
        ta = m_map[sa];
        tb = m_map[sb];
        chk("R3", "a_tag", int'(dec_a_tag), ta);
        chk("R3", "b_tag", int'(dec_b_tag), tb);
        chk("R4", "a_rdy", int'(dec_a_rdy), int'(m_bound[ta]));
        chk("R4", "b_rdy", int'(dec_b_rdy), int'(m_bound[tb]));
        chk("R4", "a_phys", int'(dec_a_phys), m_bound[ta] ? m_pmap[ta] : 0);
        chk("R4", "b_phys", int'(dec_b_phys), m_bound[tb] ? m_pmap[tb] : 0);
        eg = wv && !m_bound[wt] && (np >= 0);
        if (wv && !eg) chk("R6", "wb_refuse", int'(wb_grant), 0);
        else           chk("R5", "wb_grant", int'(wb_grant), int'(eg));
        if (eg) chk("R5", "wb_phys", int'(wb_phys), np);
        else    chk("R6", "wb_phys_zero", int'(wb_phys), 0);
        ea = cv && (m_q.size() > 0);
        if (cv && m_q.size() == 0) chk("R8", "cm_accept_empty", int'(cm_accept), 0);
        else                       chk("R7", "cm_accept", int'(cm_accept), int'(ea));
        if (ea) begin
            old = m_q[0].old_t;
            chk("R7", "rel_tag", int'(cm_rel_tag), old);
            chk("R7", "rel_phys_vld", int'(cm_rel_phys_vld), int'(m_bound[old]));
            if (m_bound[old]) chk("R7", "rel_phys", int'(cm_rel_phys), m_pmap[old]);
        end
        last_fire = dv && er;
        // update model to the state after this clock edge
        if (ea) begin
            old = m_q[0].old_t;
            void'(m_q.pop_front());
            m_tfree[old] = 1'b1;
            if (m_bound[old]) m_pfree[m_pmap[old]] = 1'b1;
            m_bound[old] = 1'b0;
        end
        if (dv && er) begin
            m_q.push_back('{old_t: m_map[sd], new_t: nt});
            m_map[sd] = nt;
            m_tfree[nt] = 1'b0;
        end
        if (eg) begin
            m_bound[wt] = 1'b1;
            m_pmap[wt]  = np;
            m_pfree[np] = 1'b0;
        end
    endtask

    task automatic rnd_step(int pd, int pw, int pc);
        int wt;
        int sd;
        if (m_q.size() > 0 && $urandom_range(0, 3) != 0)
            wt = m_q[$urandom_range(0, m_q.size() - 1)].new_t;
        else
            wt = m_map[$urandom_range(0, 31)];
        sd = $urandom_range(0, 31);
        step($urandom_range(0, 99) < pd,
             ($urandom_range(0, 3) == 0) ? sd : int'($urandom_range(0, 31)),
             $urandom_range(0, 31), sd,
             $urandom_range(0, 99) < pw, wt,
             $urandom_range(0, 99) < pc);
    endtask

    initial begin
        int fires;
        for (int i = 0; i < 32; i++) m_map[i] = i;
        for (int i = 0; i < 64; i++) begin
            m_bound[i] = (i < 32);
            m_pmap[i]  = (i < 32) ? i : 0;
            m_tfree[i] = (i >= 32);
        end
        for (int i = 0; i < 48; i++) m_pfree[i] = (i >= 32);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        dec_src_a = lreg_t'(7);
        dec_src_b = lreg_t'(31);
        #1;
        chk("R1", "reset dec_ready", int'(dec_ready), 1);
        chk("R1", "reset dst_tag", int'(dec_dst_tag), 32);
        chk("R1", "reset a_tag", int'(dec_a_tag), 7);
        chk("R1", "reset a_rdy", int'(dec_a_rdy), 1);
        chk("R1", "reset a_phys", int'(dec_a_phys), 7);
        chk("R1", "reset b_phys", int'(dec_b_phys), 31);
        chk("R1", "reset cm_accept", int'(cm_accept), 0);

        // same-register source/destination in one cycle (R3)
        step(1, 4, 4, 4, 0, 0, 0);
        step(0, 4, 3, 0, 0, 0, 0);

        // decode-heavy burst: fills record, exercises stall (R9)
        repeat (300) rnd_step(90, 10, 5);
        // writeback-heavy, no commits: physical pool runs dry (R6)
        repeat (300) rnd_step(20, 90, 0);
        // mixed traffic
        repeat (2500) rnd_step(50, 50, 40);

        // drain the record, then count decodes until stall (R10)
        for (int k = 0; k < 64 && m_q.size() > 0; k++) step(0, 0, 0, 0, 0, 0, 1);
        chk("R8", "drained", m_q.size(), 0);
        step(0, 0, 0, 0, 0, 0, 1);
        fires = 0;
        for (int k = 0; k < 40; k++) begin
            step(1, k % 32, 0, k % 32, 0, 0, 0);
            if (last_fire) fires++;
        end
        chk("R10", "tags available after drain", fires, 32);

        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R9 act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule